// File: doc/BRIEF.md
# Interconnect Test Vector Generator

This block produces the stimulus patterns for a board interconnect test. Each of up to 64 nets gets a code word. The block emits one test vector at a time as a serial stream for a boundary scan chain. Vector k carries bit k of every net's code word. A host latches a net count, a sequence mode and a code width with a start pulse. The block then shifts the first vector out. After each vector it waits for a next pulse before it shifts the following one.

The sequence modes are:

- **Counting:** each net's code is its own number. The all-zero and all-one codes never occur, so one pattern set exposes both shorts and stuck-at faults.
- **Counting plus complement:** the counting pass is followed by its inverted copy, which separates nets caught in multi-net shorts.
- **Walking one and walking zero:** a single 1, or a single 0, moves across the nets.
- **Minimal weight:** codes are handed out in rising order of set-bit count.

The block produces stimulus only. Response capture and diagnosis happen elsewhere.

Top module: `itv_gen`

## Requirements
- R1: After reset, `ser_valid_o` and `done_o` are 0 and `vec_idx_o` is 0.
- R2: A `start_i` pulse while idle latches `net_count_i`, `mode_i` and `width_i`. Later changes on these inputs have no effect on the run. The first vector begins on the next cycle. Every vector takes exactly n cycles with `ser_valid_o` high and one bit per cycle. Net n is shifted first and net 1 last.
- R3: Mode 0, and the unassigned codes 5, 6 and 7, select counting. There are W = ceil(log2(n+2)) vectors. In vector k, the bit for net j is bit k of the binary value j.
- R4: Mode 1 gives 2W vectors. Vectors 0..W-1 are the counting vectors. Vector W+k is the bitwise inverse of vector k.
- R5: Mode 2 (walking one) gives n vectors. In vector k, only net k+1 is 1. Mode 3 (walking zero) gives n vectors. In vector k, only net k+1 is 0.
- R6: Mode 4 (minimal weight) gives w vectors, where w is `width_i` and a width of 0 counts as 1. The codes are the values 1..2^w-2. They are ordered by number of set bits, then by value, and given to nets 1, 2, ... in that order. Nets left without a code get all zeros.
- R7: Between vectors the block waits with `ser_valid_o` low and `vec_idx_o` holding the index just sent. A `next_i` pulse while waiting starts the next vector on the following cycle, with the index one higher. A `next_i` pulse at any other time has no effect.
- R8: `done_o` is high for exactly one cycle. That cycle comes right after the last bit of the final vector, and `ser_valid_o` is low in it.
- R9: A start with a net count of 0 raises `done_o` on the next cycle, and no bit is shifted.
- R10: A `start_i` pulse while a vector is shifting or while the block waits between vectors has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| next_i | input | 1 | Request for the next vector, accepted while waiting |
| net_count_i | input | 7 | Number of nets n, 0..64 |
| mode_i | input | 3 | Sequence mode |
| width_i | input | 3 | Code width for minimal weight mode |
| ser_bit_o | output | 1 | Serial stimulus bit |
| ser_valid_o | output | 1 | High while a vector bit is on `ser_bit_o` |
| vec_idx_o | output | 7 | Index of the current vector |
| done_o | output | 1 | One-cycle pulse after the final vector |

## Verification
The hardest state to reach from the ports is a request that arrives while the block is not able to take it. Examples are a start or next pulse in the middle of a vector's shift, and a start during the wait between vectors. In both cases the sequence must carry on untouched. The stimulus injects these pulses at the middle bit of chosen vectors and inside the waiting gaps. It also scrambles the configuration inputs right after each start. The vector comparison then shows whether anything was disturbed. The rarer coding corners are forced by directed cases: minimal weight runs with more nets than codes, the full 64-net count, a zero width and the unassigned mode codes. Random runs with random gaps cover the rest.

// File: rtl/itv_pkg.sv
package itv_pkg;

  parameter int ITV_CW_MAX = 7;

  typedef enum logic [2:0] {
    M_COUNT = 3'd0,
    M_COMPL = 3'd1,
    M_WALK1 = 3'd2,
    M_WALK0 = 3'd3,
    M_MINW  = 3'd4
  } itv_mode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SHIFT = 2'd1,
    S_WAIT  = 2'd2
  } itv_state_e;

  // smallest r with 2^r >= n+2
  function automatic int count_width(input int n);
    int r;
    r = 0;
    for (int i = 0; i <= ITV_CW_MAX; i++)
      if ((1 << i) < n + 2) r = i + 1;
    return r;
  endfunction

  // code of net 'net' in minimal weight order for a width of 'width'
  function automatic int mw_code(input int net, input int width);
    int lim, rank, res;
    lim  = (1 << width) - 1;
    rank = 0;
    res  = 0;
    for (int wt = 1; wt < ITV_CW_MAX; wt++)
      for (int v = 1; v < (1 << ITV_CW_MAX) - 1; v++)
        if (v < lim && $countones(v) == wt) begin
          rank = rank + 1;
          if (rank == net) res = v;
        end
    return res;
  endfunction

  function automatic int vec_total(input int mode, input int n, input int width);
    case (mode)
      int'(M_COMPL): return 2 * count_width(n);
      int'(M_WALK1),
      int'(M_WALK0): return n;
      int'(M_MINW):  return width;
      default:       return count_width(n);
    endcase
  endfunction

endpackage

// File: rtl/itv_cfg.sv
module itv_cfg
  import itv_pkg::*;
#(
  parameter int NET_W = 7,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NET_W-1:0] nets_in,
  input  logic [2:0]       mode_in,
  input  logic [2:0]       width_in,
  output logic [NET_W-1:0] nets_q,
  output logic [2:0]       mode_q,
  output logic [2:0]       width_q,
  output logic [IDX_W-1:0] total_q
);

  logic [2:0]       width_eff;
  logic [IDX_W-1:0] total_d;

  assign width_eff = (width_in == 3'd0) ? 3'd1 : width_in;
  assign total_d   = IDX_W'(vec_total(int'(mode_in), int'(nets_in), int'(width_eff)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nets_q  <= '0;
      mode_q  <= '0;
      width_q <= 3'd1;
      total_q <= '0;
    end else if (load) begin
      nets_q  <= nets_in;
      mode_q  <= mode_in;
      width_q <= width_eff;
      total_q <= total_d;
    end
  end

endmodule

// File: rtl/itv_seq.sv
module itv_seq
  import itv_pkg::*;
#(
  parameter int NET_W = 7,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             next,
  input  logic [NET_W-1:0] nets_in,
  input  logic [NET_W-1:0] nets_q,
  input  logic [IDX_W-1:0] total_q,
  output logic             launch,
  output logic             resume,
  output logic             last_bit,
  output logic             shifting,
  output logic [IDX_W-1:0] vec_q,
  output logic [NET_W-1:0] net_q,
  output logic             done_q
);

  itv_state_e state;

  assign shifting = (state == S_SHIFT);
  assign launch   = (state == S_IDLE) && start;
  assign resume   = (state == S_WAIT) && next;
  assign last_bit = shifting && (net_q == NET_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      vec_q  <= '0;
      net_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            vec_q <= '0;
            if (nets_in == '0) begin
              done_q <= 1'b1;
            end else begin
              net_q <= nets_in;
              state <= S_SHIFT;
            end
          end
        end
        S_SHIFT: begin
          if (last_bit) begin
            if (vec_q == total_q - IDX_W'(1)) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              state <= S_WAIT;
            end
          end else begin
            net_q <= net_q - NET_W'(1);
          end
        end
        S_WAIT: begin
          if (next) begin
            vec_q <= vec_q + IDX_W'(1);
            net_q <= nets_q;
            state <= S_SHIFT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/itv_bitgen.sv
module itv_bitgen
  import itv_pkg::*;
#(
  parameter int NET_W = 7,
  parameter int IDX_W = 7
) (
  input  logic [2:0]       mode_q,
  input  logic [2:0]       width_q,
  input  logic [NET_W-1:0] nets_q,
  input  logic [IDX_W-1:0] vec_q,
  input  logic [NET_W-1:0] net_q,
  output logic             bit_o
);

  always_comb begin
    int nn, jj, kk, cw;
    nn = int'(nets_q);
    jj = int'(net_q);
    kk = int'(vec_q);
    cw = count_width(nn);
    case (mode_q)
      M_COMPL: begin
        if (kk < cw) bit_o = ((jj >> kk) & 1) != 0;
        else         bit_o = ((jj >> (kk - cw)) & 1) == 0;
      end
      M_WALK1: bit_o = (jj == kk + 1);
      M_WALK0: bit_o = (jj != kk + 1);
      M_MINW:  bit_o = ((mw_code(jj, int'(width_q)) >> kk) & 1) != 0;
      default: bit_o = ((jj >> kk) & 1) != 0;
    endcase
  end

endmodule

// File: rtl/itv_gen.sv
module itv_gen
  import itv_pkg::*;
#(
  parameter int MAX_NETS = 64,
  localparam int NET_W = $clog2(MAX_NETS + 1),
  localparam int IDX_W = NET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             next_i,
  input  logic [NET_W-1:0] net_count_i,
  input  logic [2:0]       mode_i,
  input  logic [2:0]       width_i,
  output logic             ser_bit_o,
  output logic             ser_valid_o,
  output logic [IDX_W-1:0] vec_idx_o,
  output logic             done_o
);

  logic             launch, resume, last_bit, shifting, done_q, bit_raw;
  logic [NET_W-1:0] nets_q, net_q;
  logic [2:0]       mode_q, width_q;
  logic [IDX_W-1:0] total_q, vec_q;

  itv_cfg #(.NET_W(NET_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .nets_in(net_count_i), .mode_in(mode_i), .width_in(width_i),
    .nets_q(nets_q), .mode_q(mode_q), .width_q(width_q), .total_q(total_q)
  );

  itv_seq #(.NET_W(NET_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_i), .next(next_i),
    .nets_in(net_count_i), .nets_q(nets_q), .total_q(total_q),
    .launch(launch), .resume(resume), .last_bit(last_bit), .shifting(shifting),
    .vec_q(vec_q), .net_q(net_q), .done_q(done_q)
  );

  itv_bitgen #(.NET_W(NET_W), .IDX_W(IDX_W)) u_bit (
    .mode_q(mode_q), .width_q(width_q), .nets_q(nets_q),
    .vec_q(vec_q), .net_q(net_q), .bit_o(bit_raw)
  );

  assign ser_valid_o = shifting;
  assign ser_bit_o   = shifting & bit_raw;
  assign vec_idx_o   = vec_q;
  assign done_o      = done_q;

endmodule

// File: rtl/itv_gen_chk.sv
module itv_gen_chk #(
  parameter int NET_W = 7,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_valid_o,
  input logic             done_o,
  input logic [IDX_W-1:0] vec_idx_o,
  input logic [NET_W-1:0] net_count_i,
  input logic             launch,
  input logic             resume,
  input logic             last_bit
);

  logic [NET_W:0]   bits_seen;
  logic [NET_W-1:0] nets_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_seen <= '0;
      nets_lat  <= '0;
    end else begin
      if (launch) begin
        nets_lat  <= net_count_i;
        bits_seen <= '0;
      end else if (ser_valid_o) begin
        bits_seen <= last_bit ? '0 : bits_seen + 1'b1;
      end
    end
  end

  // R8
  valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_valid_o && done_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_o && !last_bit) |=> (ser_valid_o && $stable(vec_idx_o)));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> (ser_valid_o && vec_idx_o == $past(vec_idx_o) + IDX_W'(1)));

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |-> (bits_seen + 1'b1 == {1'b0, nets_lat}));

  // R9
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && net_count_i == '0) |=> (done_o && !ser_valid_o));

endmodule

bind itv_gen itv_gen_chk #(.NET_W(NET_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_valid_o(ser_valid_o), .done_o(done_o),
  .vec_idx_o(vec_idx_o), .net_count_i(net_count_i),
  .launch(launch), .resume(resume), .last_bit(last_bit)
);

// File: tb/itv_gen_bench.sv
module itv_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       next_i = 1'b0;
  logic [6:0] net_count_i = '0;
  logic [2:0] mode_i = '0;
  logic [2:0] width_i = '0;
  logic       ser_bit_o, ser_valid_o, done_o;
  logic [6:0] vec_idx_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  itv_gen u_itv_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_i(next_i),
    .net_count_i(net_count_i), .mode_i(mode_i), .width_i(width_i),
    .ser_bit_o(ser_bit_o), .ser_valid_o(ser_valid_o),
    .vec_idx_o(vec_idx_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int b_width(input int n);
    int r = 0;
    while ((1 << r) < n + 2) r++;
    return r;
  endfunction

  function automatic int b_total(input int mode, input int n, input int w);
    if (mode == 1) return 2 * b_width(n);
    if (mode == 2 || mode == 3) return n;
    if (mode == 4) return w;
    return b_width(n);
  endfunction

  function automatic int b_mw(input int net, input int w);
    int lst[$];
    for (int wt = 1; wt < w; wt++)
      for (int v = 1; v <= (1 << w) - 2; v++)
        if ($countones(v) == wt) lst.push_back(v);
    if (net <= lst.size()) return lst[net - 1];
    return 0;
  endfunction

  function automatic bit b_bit(input int mode, input int k, input int j,
                               input int n, input int w);
    int cw = b_width(n);
    case (mode)
      1: return (k < cw) ? j[k] : !j[k - cw];
      2: return j == k + 1;
      3: return j != k + 1;
      4: return b_mw(j, w) >> k & 1;
      default: return j[k];
    endcase
  endfunction

  function automatic string mode_req(input int mode);
    if (mode == 1) return "R4";
    if (mode == 2 || mode == 3) return "R5";
    if (mode == 4) return "R6";
    return "R3";
  endfunction

  task automatic run_case(input int n, input int mode, input int w, input bit disturb);
    int weff = (w == 0) ? 1 : w;
    int tot = b_total(mode, n, weff);
    int gap;
    logic [63:0] got, exp;
    @(negedge clk);
    net_count_i = 7'(n); mode_i = 3'(mode); width_i = 3'(w); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2: scramble configuration after the latch
    net_count_i = 7'($urandom % 65); mode_i = 3'($urandom); width_i = 3'($urandom);
    if (n == 0) begin
      chk(done_o && !ser_valid_o, "R9", "empty start done", {62'b0, done_o, ser_valid_o}, 64'h2);
      @(negedge clk);
      chk(!done_o, "R8", "empty done width", {63'b0, done_o}, 64'h0);
      return;
    end
    for (int v = 0; v < tot; v++) begin
      got = '0; exp = '0;
      for (int i = 0; i < n; i++) begin
        if (!ser_valid_o) begin
          chk(1'b0, "R2", "valid during shift", 64'(i), 64'(n));
        end
        if (i == 0) chk(vec_idx_o == 7'(v), "R7", "vector index", 64'(vec_idx_o), 64'(v));
        got[n - 1 - i] = ser_bit_o;
        if (disturb && i == n / 2) begin
          start_i = 1'b1; next_i = 1'b1;   // R10 / R7: ignored mid-shift
        end else begin
          start_i = 1'b0; next_i = 1'b0;
        end
        @(negedge clk);
      end
      start_i = 1'b0; next_i = 1'b0;
      for (int j = 1; j <= n; j++) exp[j - 1] = b_bit(mode, v, j, n, weff);
      chk(got == exp, mode_req(mode), $sformatf("vector %0d n=%0d mode=%0d", v, n, mode), got, exp);
      chk(!ser_valid_o, "R2", "vector length", {63'b0, ser_valid_o}, 64'h0);
      if (v == tot - 1) begin
        chk(done_o, "R8", "done after final vector", {63'b0, done_o}, 64'h1);
        @(negedge clk);
        chk(!done_o && !ser_valid_o, "R8", "done one cycle", {62'b0, done_o, ser_valid_o}, 64'h0);
      end else begin
        chk(!done_o, "R8", "no early done", {63'b0, done_o}, 64'h0);
        gap = $urandom % 4;
        for (int g = 0; g < gap; g++) begin
          if (disturb && g == 0) start_i = 1'b1;   // R10: start while waiting
          @(negedge clk);
          start_i = 1'b0;
          chk(!ser_valid_o && vec_idx_o == 7'(v), "R7", "waits for next",
              {56'b0, ser_valid_o, vec_idx_o}, 64'(v));
        end
        next_i = 1'b1;
        @(negedge clk);
        next_i = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0DE));
    repeat (3) @(negedge clk);
    // R1
    chk(!ser_valid_o && !done_o && vec_idx_o == 0, "R1", "reset state",
        {55'b0, ser_valid_o, done_o, vec_idx_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: next with no run in progress does nothing
    next_i = 1'b1; @(negedge clk); next_i = 1'b0;
    chk(!ser_valid_o && !done_o, "R7", "next while idle", {62'b0, ser_valid_o, done_o}, 64'h0);
    run_case(0, 0, 3, 0);   // R9
    run_case(1, 0, 3, 1);   // R3 smallest
    run_case(64, 0, 3, 0);  // R3 full count
    run_case(64, 1, 3, 1);  // R4
    run_case(5, 2, 3, 1);   // R5 walking one
    run_case(7, 3, 3, 0);   // R5 walking zero
    run_case(6, 4, 3, 0);   // R6 exact fit
    run_case(10, 4, 3, 1);  // R6 more nets than codes
    run_case(3, 4, 0, 0);   // R6 zero width
    run_case(20, 4, 7, 0);  // R6 widest
    run_case(12, 6, 2, 0);  // R3 unassigned mode code
    for (int r = 0; r < 20; r++)
      run_case($urandom % 65, $urandom % 8, $urandom % 8, $urandom % 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule